// File: doc/BRIEF.md
# Asynchronous Serial Link with In-Frame Parity

This block is a full-duplex asynchronous serial port: one transmitter and one receiver, both clocked from a single programmable rate generator. A 13-bit divisor sets the bit period to 32 times the divisor in system clocks. The generator emits a sampling tick at 16 times the bit rate. The transmitter counts 16 ticks per bit. The receiver uses the same ticks to find the middle of each bit, and it moves its phase whenever it sees an edge on the incoming line.

The frame is a fixed number of bit positions: one low start bit, then either 8 or 7 positions sent LSB first, then one high stop bit. The line idles high. When parity is on, the last position before the stop bit carries the parity bit in place of the top data bit, so the frame keeps the same length and holds one data bit less. One even/odd control applies to both directions. The receiver hands each frame out with a one-cycle strobe. It keeps sticky flags for parity and stop-bit errors, and a strobe clears them.

Bytes enter through a valid/ready handshake. The system reset is asynchronous and active low, and the block releases it synchronously.

Top module: `uart_par_link`

## Requirements
- R1: Every serial bit lasts 32 x `baud_div` system clocks (32 clocks at divisor 1, 4160 clocks at divisor 130).
- R2: A divisor of 0 stops the rate generator. `tx_ready` then stays low, no byte is accepted and `ser_tx` stays high.
- R3: `ser_tx` idles high. A frame is a low start bit, then the positions LSB first, then a high stop bit.
- R4: `tx_ready` is high when the transmitter is idle and the divisor is nonzero. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low from the next cycle until the stop bit ends.
- R5: The number of positions is 8 when `frame_short`=0 and 7 when it is 1. With `par_en`=0 every position carries data bit i. With `par_en`=1 the top position carries parity and the lower positions carry data bits 0 upward.
- R6: With `par_odd`=0 the count of ones over all positions, parity included, is even. With `par_odd`=1 it is odd. The same rule is generated on transmit and checked on receive.
- R7: The receiver raises `rx_valid` for one cycle near the middle of the stop bit. `rx_data` holds the received data bits, and the bits above the data count are zero.
- R8: A parity mismatch on a received frame (with `par_en`=1) sets `par_err`. The flag stays set until it is cleared.
- R9: A low stop-bit sample sets `frm_err`. The flag stays set until it is cleared.
- R10: An `err_clr` pulse clears both flags. A new error in the same cycle wins over the clear.
- R11: A low pulse on `ser_rx` that is gone by the middle of the start bit does not start a frame.
- R12: The receiver re-centres on each line edge. A sender whose bits are 6% longer is still received correctly when the data toggles every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 13 | Rate divisor; 0 stops the generator |
| par_en | input | 1 | Parity position enabled |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| frame_short | input | 1 | 0: 8 positions, 1: 7 positions |
| err_clr | input | 1 | Clears both error flags |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| rx_data | output | 8 | Received data, zero-extended |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky stop-bit error |
| ser_tx | output | 1 | Serial output line |
| ser_rx | input | 1 | Serial input line |

## Verification
Timing is counted from the clock edge that accepts a byte. `tx_ready` must be low one cycle after that edge. The line level of bit k is due at 32·k·div + 16·div clocks after it. The bench samples at exactly those centres, so a drifting bit period pushes a sample into the wrong bit. Receive results are due after two synchroniser stages, up to one tick of alignment and 9.6 bit times of frame, so the bench reads the captured byte, strobe count and flags one full bit after the stop-bit centre. Injected frames, glitches and slow-sender frames are driven cycle by cycle from the bench with their expected data worked out in advance.

// File: rtl/uart_par_pkg.sv
`timescale 1ns/1ps
package uart_par_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_par_baud.sv
`timescale 1ns/1ps
module uart_par_baud #(
  parameter int DIV_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit  = {div_i, 1'b0} - CNT_W'(1);
    tick_o = 1'b0;
    cnt_d  = cnt_q + CNT_W'(1);
    if (div_i == '0) begin
      cnt_d = '0;
    end else if (cnt_q >= limit) begin
      cnt_d  = '0;
      tick_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_tick_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(div_i) == '0 && div_i == '0) |-> !tick_o);

endmodule

// File: rtl/uart_par_tx.sv
`timescale 1ns/1ps
module uart_par_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              short_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              line_o
);
  localparam int FRM_W  = DATA_W + 2;
  localparam int LEFT_W = $clog2(FRM_W + 1);

  logic              busy_q, busy_d;
  logic [FRM_W-1:0]  frame_q, frame_d, frm;
  logic [LEFT_W-1:0] left_q, left_d;
  logic [3:0]        ph_q, ph_d;
  logic [DATA_W-1:0] pos;
  logic              par, accept;
  int                npos;

  assign ready_o = !busy_q && en_i;
  assign accept  = valid_i && ready_o;
  assign line_o  = frame_q[0];

  // frame image: start, positions (parity in the top one), stop ones
  always_comb begin
    npos = short_i ? DATA_W - 1 : DATA_W;
    par  = par_odd_i;
    pos  = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < npos)     pos[i] = data_i[i];
      if (i < npos - 1) par    = par ^ data_i[i];
    end
    if (par_en_i) pos[npos-1] = par;
    frm    = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < npos) frm[i+1] = pos[i];
    end
  end

  always_comb begin
    busy_d  = busy_q;
    frame_d = frame_q;
    left_d  = left_q;
    ph_d    = ph_q;
    if (accept) begin
      busy_d  = 1'b1;
      frame_d = frm;
      left_d  = LEFT_W'(npos + 2);
      ph_d    = '0;
    end else if (busy_q && tick_i) begin
      ph_d = ph_q + 4'd1;
      if (ph_q == 4'd15) begin
        frame_d = {1'b1, frame_q[FRM_W-1:1]};
        left_d  = left_q - LEFT_W'(1);
        if (left_q == LEFT_W'(1)) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      left_q  <= '0;
      ph_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      frame_q <= frame_d;
      left_q  <= left_d;
      ph_q    <= ph_d;
    end
  end

  assert_ready_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);

  assert_idle_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> line_o);

  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !line_o);

endmodule

// File: rtl/uart_par_rx.sv
`timescale 1ns/1ps
module uart_par_rx
  import uart_par_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              short_i,
  input  logic              clr_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  rx_state_e         st_q, st_d;
  logic              s1_q, s2_q, prev_q, prev_d;
  logic [3:0]        ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, data_q, data_d, pos_v;
  logic              v7_q, v7_d, v8_q, v8_d, vb_q, vb_d;
  logic              valid_q, valid_d, perr_q, perr_d, ferr_q, ferr_d;
  logic              edge_s, vote, bad_par;
  int                npos;

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    npos    = short_i ? DATA_W - 1 : DATA_W;
    edge_s  = tick_i && (s2_q != prev_q);
    vote    = maj3(v7_q, v8_q, s2_q);
    pos_v   = short_i ? {1'b0, sh_q[DATA_W-1:1]} : sh_q;
    bad_par = par_en_i && ((^pos_v) != par_odd_i);

    st_d    = st_q;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    v7_d    = v7_q;
    v8_d    = v8_q;
    vb_d    = vb_q;
    data_d  = data_q;
    valid_d = 1'b0;
    prev_d  = tick_i ? s2_q : prev_q;
    perr_d  = clr_i ? 1'b0 : perr_q;
    ferr_d  = clr_i ? 1'b0 : ferr_q;

    if (tick_i) begin
      if (ph_q == 4'd7) v7_d = s2_q;
      if (ph_q == 4'd8) v8_d = s2_q;
      unique case (st_q)
        RX_IDLE: begin
          if (!s2_q) begin
            st_d = RX_START;
            ph_d = '0;
          end
        end
        RX_START: begin
          ph_d = ph_q + 4'd1;
          if (ph_q == 4'd7 && s2_q) st_d = RX_IDLE;
          else if (ph_q == 4'd15) begin
            st_d  = RX_DATA;
            cnt_d = '0;
          end
        end
        RX_DATA: begin
          if (ph_q == 4'd9) vb_d = vote;
          if (ph_q == 4'd15 || (edge_s && ph_q >= 4'd12)) begin
            sh_d  = {vb_q, sh_q[DATA_W-1:1]};
            cnt_d = cnt_q + CNT_W'(1);
            ph_d  = '0;
            if (cnt_q == CNT_W'(npos - 1)) st_d = RX_STOP;
          end else if (edge_s && ph_q <= 4'd4) begin
            ph_d = '0;
          end else begin
            ph_d = ph_q + 4'd1;
          end
        end
        RX_STOP: begin
          if (ph_q == 4'd9) begin
            st_d    = RX_IDLE;
            valid_d = 1'b1;
            data_d  = pos_v;
            if (par_en_i) data_d[npos-1] = 1'b0;
            if (bad_par) perr_d = 1'b1;
            if (!vote)   ferr_d = 1'b1;
          end else if (edge_s && ph_q <= 4'd4) begin
            ph_d = '0;
          end else begin
            ph_d = ph_q + 4'd1;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      ph_q    <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      v7_q    <= 1'b1;
      v8_q    <= 1'b1;
      vb_q    <= 1'b1;
      data_q  <= '0;
      valid_q <= 1'b0;
      prev_q  <= 1'b1;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      v7_q    <= v7_d;
      v8_q    <= v8_d;
      vb_q    <= vb_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      prev_q  <= prev_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  assert_perr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_q && !clr_i) |=> perr_q);

  assert_ferr_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_q && !clr_i) |=> ferr_q);

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((!perr_q && !ferr_q) || valid_q));

  assert_flag_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perr_q) |-> valid_q);

endmodule

// File: rtl/uart_par_link.sv
`timescale 1ns/1ps
module uart_par_link #(
  parameter int DIV_W  = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              frame_short,
  input  logic              err_clr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err,
  output logic              ser_tx,
  input  logic              ser_rx
);
  logic rst_m_q, rst_s_q, tick;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  uart_par_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk),
    .rst_ni (rst_s_q),
    .div_i  (baud_div),
    .tick_o (tick)
  );

  uart_par_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i     (clk),
    .rst_ni    (rst_s_q),
    .tick_i    (tick),
    .en_i      (baud_div != '0),
    .par_en_i  (par_en),
    .par_odd_i (par_odd),
    .short_i   (frame_short),
    .data_i    (tx_data),
    .valid_i   (tx_valid),
    .ready_o   (tx_ready),
    .line_o    (ser_tx)
  );

  uart_par_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk),
    .rst_ni    (rst_s_q),
    .tick_i    (tick),
    .par_en_i  (par_en),
    .par_odd_i (par_odd),
    .short_i   (frame_short),
    .clr_i     (err_clr),
    .line_i    (ser_rx),
    .data_o    (rx_data),
    .valid_o   (rx_valid),
    .perr_o    (par_err),
    .ferr_o    (frm_err)
  );

endmodule

// File: tb/uart_par_link_bench.sv
`timescale 1ns/1ps
module uart_par_link_bench;
  localparam real CLK_PERIOD = 25.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] baud_div = 13'd1;
  logic        par_en = 1'b0, par_odd = 1'b0, frame_short = 1'b0;
  logic        err_clr = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_valid = 1'b0;
  logic        tx_ready, rx_valid, par_err, frm_err, ser_tx, ser_rx;
  logic [7:0]  rx_data;
  logic        inj_sel = 1'b0, inj_line = 1'b1;

  int         n_chk = 0, n_err = 0, got_n = 0;
  logic [7:0] got_data = 8'h00;

  always #(CLK_PERIOD / 2.0) clk = ~clk;
  assign ser_rx = inj_sel ? inj_line : ser_tx;

  always @(posedge clk) if (rx_valid) begin
    got_data <= rx_data;
    got_n    <= got_n + 1;
  end

  uart_par_link u_uart_par_link (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .par_en(par_en),
    .par_odd(par_odd), .frame_short(frame_short), .err_clr(err_clr),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err),
    .frm_err(frm_err), .ser_tx(ser_tx), .ser_rx(ser_rx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pos(input logic [7:0] d, input bit pe,
                                         input bit odd, input bit shrt);
    int npos = shrt ? 7 : 8;
    int nd = pe ? npos - 1 : npos;
    int ones = 0;
    logic [7:0] p = '0;
    for (int i = 0; i < nd; i++) begin
      p[i] = d[i];
      if (d[i]) ones++;
    end
    if (pe) p[npos-1] = odd ^ (ones % 2 == 1);
    return p;
  endfunction

  task automatic setup(input int div, input bit pe, input bit odd, input bit shrt);
    @(negedge clk);
    baud_div = 13'(div); par_en = pe; par_odd = odd; frame_short = shrt;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ser_tx === 1'b1, "R3 idle line after reset", ser_tx, 1);
    chk(tx_ready === 1'b1, "R4 ready after reset", tx_ready, 1);
    chk(rx_valid === 1'b0, "R7 no strobe after reset", rx_valid, 0);
    chk(par_err === 1'b0 && frm_err === 1'b0, "R8 R9 flags after reset",
        {par_err, frm_err}, 0);
  endtask

  // send one byte in loopback, check each bit centre and the received byte
  task automatic t_loop(input logic [7:0] d, input bit pe, input bit odd,
                        input bit shrt, input int div);
    int npos = shrt ? 7 : 8;
    int nd = pe ? npos - 1 : npos;
    logic [7:0] p = exp_pos(d, pe, odd, shrt);
    logic [7:0] ed = d & 8'((1 << nd) - 1);
    int n0;
    inj_sel = 1'b0;
    setup(div, pe, odd, shrt);
    n0 = got_n;
    chk(tx_ready === 1'b1, "R4 ready before send", tx_ready, 1);
    tx_data = d; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready === 1'b0, "R4 ready drops after accept", tx_ready, 0);
    repeat (16 * div) @(negedge clk);
    chk(ser_tx === 1'b0, "R3 start bit low", ser_tx, 0);
    for (int k = 0; k < npos; k++) begin
      repeat (32 * div) @(negedge clk);
      chk(ser_tx === p[k], "R1 R5 R6 position level", ser_tx, p[k]);
    end
    repeat (32 * div) @(negedge clk);
    chk(ser_tx === 1'b1, "R3 stop bit high", ser_tx, 1);
    repeat (32 * div) @(negedge clk);
    chk(tx_ready === 1'b1, "R4 ready after frame", tx_ready, 1);
    chk(got_n == n0 + 1, "R7 one strobe per frame", got_n - n0, 1);
    chk(got_data === ed, "R7 received data", got_data, ed);
    chk(par_err === 1'b0, "R6 R8 no parity error on good frame", par_err, 0);
  endtask

  task automatic t_div_off;
    int n0 = got_n;
    inj_sel = 1'b0;
    setup(0, 1'b0, 1'b0, 1'b0);
    tx_data = 8'h0F; tx_valid = 1'b1;
    repeat (200) @(negedge clk);
    chk(tx_ready === 1'b0, "R2 ready low with divisor 0", tx_ready, 0);
    chk(ser_tx === 1'b1, "R2 line stays high with divisor 0", ser_tx, 1);
    tx_valid = 1'b0;
    setup(1, 1'b0, 1'b0, 1'b0);
    repeat (400) @(negedge clk);
    chk(ser_tx === 1'b1 && tx_ready === 1'b1, "R2 nothing was accepted",
        {ser_tx, tx_ready}, 3);
    chk(got_n == n0, "R2 no frame sent", got_n - n0, 0);
  endtask

  task automatic inj_frame(input logic [7:0] p, input int npos, input bit stopb,
                           input int stop_len, input int per);
    @(negedge clk);
    inj_line = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < npos; i++) begin
      inj_line = p[i];
      repeat (per) @(negedge clk);
    end
    inj_line = stopb;
    repeat (stop_len) @(negedge clk);
    inj_line = 1'b1;
    repeat (4 * per) @(negedge clk);
  endtask

  task automatic t_par_err;
    int n0;
    setup(1, 1'b1, 1'b0, 1'b0);
    inj_sel = 1'b1;
    repeat (20) @(negedge clk);
    n0 = got_n;
    inj_frame(8'h01, 8, 1'b1, 32, 32);
    chk(got_n == n0 + 1, "R8 frame with bad parity delivered", got_n - n0, 1);
    chk(got_data === 8'h01, "R8 data of bad parity frame", got_data, 8'h01);
    chk(par_err === 1'b1, "R8 parity error set", par_err, 1);
    chk(frm_err === 1'b0, "R9 no framing error", frm_err, 0);
  endtask

  task automatic t_frm_err;
    int n0 = got_n;
    inj_frame(8'h81, 8, 1'b0, 24, 32);
    chk(got_n == n0 + 1, "R9 exactly one frame", got_n - n0, 1);
    chk(frm_err === 1'b1, "R9 framing error set", frm_err, 1);
    chk(par_err === 1'b1, "R8 parity flag still set", par_err, 1);
  endtask

  task automatic t_clear;
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
    chk(par_err === 1'b0 && frm_err === 1'b0, "R10 clear strobe",
        {par_err, frm_err}, 0);
  endtask

  task automatic t_glitch;
    int n0 = got_n;
    @(negedge clk);
    inj_line = 1'b0;
    repeat (6) @(negedge clk);
    inj_line = 1'b1;
    repeat (400) @(negedge clk);
    chk(got_n == n0, "R11 short low pulse ignored", got_n - n0, 0);
    chk(frm_err === 1'b0, "R11 no error from glitch", frm_err, 0);
  endtask

  task automatic t_slow;
    int n0;
    setup(1, 1'b0, 1'b0, 1'b0);
    n0 = got_n;
    inj_frame(8'h55, 8, 1'b1, 34, 34);
    chk(got_n == n0 + 1, "R12 slow frame delivered", got_n - n0, 1);
    chk(got_data === 8'h55, "R12 slow frame data", got_data, 8'h55);
    chk(frm_err === 1'b0, "R12 slow frame stop bit", frm_err, 0);
    inj_sel = 1'b0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_loop(8'hA5, 1'b0, 1'b0, 1'b0, 1);
    t_loop(8'h53, 1'b1, 1'b0, 1'b0, 1);
    t_loop(8'h53, 1'b1, 1'b1, 1'b0, 1);
    t_loop(8'h35, 1'b1, 1'b1, 1'b1, 1);
    t_loop(8'hC9, 1'b0, 1'b0, 1'b1, 1);
    t_div_off();
    t_par_err();
    t_frm_err();
    t_clear();
    t_glitch();
    t_slow();
    t_loop(8'h3C, 1'b0, 1'b0, 1'b0, 130);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule